// File: doc/BRIEF.md
# Multi-Mode Serial DAC Control Port

This block is the serial slave port of a multi-channel DAC controller. A host frames 24-bit words with an active-low frame strobe and clocks them in MSB first. When the strobe returns high, the port turns the frame into a single-cycle request to the internal register bank. The request is either a write (address plus data) or a read (address only).

All pins are first brought into the system clock domain through two-stage synchronizers. SCLK edges and frame boundaries are detected in that domain. The block has three modes. In standalone mode each frame is a write. Readback is requested per frame by a flag bit, and the addressed register is shifted out during the next frame. When the static `daisy_en` input is high, incoming bits pass through to the serial output one frame length later, so several ports can share one chain.

After each accepted write, a busy flag stays high for a fixed number of system cycles. The serial output changes on falling SCLK edges, so the host samples it on rising edges. The port drives the pad enable only while a frame is open.

Top module: `dac_serial_port`

## Requirements
- R1: After reset `req_valid`, `busy`, `sdo` and `sdo_oe` are all 0.
- R2: A frame is shifted in MSB first, one bit per rising SCLK edge while `sync_n` is low. Bit 23 is the read flag, bits 22:16 are the address and bits 15:0 are the data. A standalone frame of exactly 24 clocks with the flag at 0 gives exactly one `req_valid` pulse with `req_write`=1 and that address and data.
- R3: In standalone mode a frame that closes after 23 or 25 clocks produces no request.
- R4: A frame whose 24 bits are all zero is a no-operation and produces no request.
- R5: A 24-bit standalone frame with the read flag at 1 issues a read request (`req_write`=0). During the next frame, `sdo` presents {0, address, `rd_data`} MSB first. Each bit is valid at the rising SCLK edge where the host samples it.
- R6: In standalone mode, `sdo` stays 0 through a frame that follows a frame which issued no read.
- R7: With `daisy_en`=1, a bit taken from `din` at rising edge k appears on `sdo` for the host to sample at rising edge k+24 of the same frame.
- R8: With `daisy_en`=1, a frame of 24 or more clocks commits its last 24 bits as a write. A shorter frame, or one whose last 24 bits carry the read flag, produces no request.
- R9: `busy` rises the cycle after a write request and stays high for `BUSY_CYC` cycles. A read request does not raise it.
- R10: `sdo_oe` is 1 while the synchronized `sync_n` is low and 0 otherwise. Requests are only issued while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| sync_n | input | 1 | Active-low frame strobe |
| din | input | 1 | Serial data in |
| daisy_en | input | 1 | Static chain-mode select |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Pad enable for `sdo` |
| req_valid | output | 1 | One-cycle request strobe |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Register address |
| req_data | output | DATA_W | Write data |
| rd_data | input | DATA_W | Register bank read data, captured one cycle after a read request |
| busy | output | 1 | Write in progress |

## Verification
Frames of 23 and 25 clocks are sent in standalone mode. A port that did not check the length exactly would issue a spurious write from a shifted word. A readback pair checks that the addressed register appears one frame later, bit-aligned to the host's sampling edges. An off-by-one shift would show up as a doubled or lost leading bit. A 48-clock chain frame checks that the first word emerges on `sdo` and the second is committed locally; a pass-through with the wrong delay, or a port committing the first 24 bits, fails there. Busy is counted cycle by cycle, so a wrong duration, or busy raised on reads, is reported.

// File: rtl/dac_serial_port.sv
module dac_serial_port #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              din,
  input  logic              daisy_en,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int FRAME = 1 + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(4 * FRAME);
  localparam int BSY_W = $clog2(BUSY_CYC + 1);

  logic [2:0] sclk_p, sync_p;
  logic [1:0] din_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      sync_p <= '1;
      din_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      sync_p <= {sync_p[1:0], sync_n};
      din_p  <= {din_p[0], din};
    end

  wire open_f   = ~sync_p[1];
  wire sc_rise  = open_f & sclk_p[1] & ~sclk_p[2];
  wire sc_fall  = open_f & ~sclk_p[1] & sclk_p[2];
  wire fr_start = ~sync_p[1] & sync_p[2];
  wire fr_end   = sync_p[1] & ~sync_p[2];

  logic [FRAME-1:0] in_sr, out_sr, rd_word;
  logic [CNT_W-1:0] cnt;
  logic             rd_have, sdo_q;
  logic [BSY_W-1:0] bcnt;

  wire len_ok = daisy_en ? (cnt >= CNT_W'(FRAME)) : (cnt == CNT_W'(FRAME));
  wire rflag  = in_sr[FRAME-1];
  wire take   = len_ok && (in_sr != '0) && !(daisy_en && rflag);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_sr <= '0;
      cnt   <= '0;
    end else if (fr_start) begin
      cnt <= '0;
    end else if (sc_rise) begin
      in_sr <= {in_sr[FRAME-2:0], din_p[1]};
      if (cnt != '1) cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      req_valid <= fr_end && take;
      if (fr_end && take) begin
        req_write <= ~rflag;
        req_addr  <= in_sr[FRAME-2:DATA_W];
        req_data  <= in_sr[DATA_W-1:0];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_have <= 1'b0;
      rd_word <= '0;
      out_sr  <= '0;
      sdo_q   <= 1'b0;
    end else begin
      if (req_valid && !req_write) begin
        rd_have <= 1'b1;
        rd_word <= {1'b0, req_addr, rd_data};
      end else if (fr_start && !daisy_en) begin
        rd_have <= 1'b0;
      end
      if (fr_start && !daisy_en) begin
        sdo_q  <= rd_have & rd_word[FRAME-1];
        out_sr <= rd_have ? {rd_word[FRAME-2:0], 1'b0} : '0;
      end else if (sc_fall) begin
        sdo_q  <= daisy_en ? in_sr[FRAME-1] : out_sr[FRAME-1];
        out_sr <= {out_sr[FRAME-2:0], 1'b0};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else if (req_valid && req_write) bcnt <= BSY_W'(BUSY_CYC);
    else if (bcnt != '0) bcnt <= bcnt - 1'b1;

  assign busy   = bcnt != '0;
  assign sdo    = sdo_q;
  assign sdo_oe = open_f;

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  assert_req_frame_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !sdo_oe);
  assert_no_read_in_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> !daisy_en);
  assert_busy_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_write));
  assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BSY_W'(BUSY_CYC));
endmodule

// File: tb/tb_dac_serial_port.sv
module tb_dac_serial_port;
  localparam int HP = 4;
  logic clk = 0, rst_n = 0, sclk = 0, sync_n = 1, din = 0, daisy_en = 0;
  logic sdo, sdo_oe, req_valid, req_write, busy;
  logic [6:0] req_addr;
  logic [15:0] req_data, rd_data;
  int checks = 0, fails = 0, nreq = 0, bcyc = 0;
  logic [47:0] cap;
  logic last_wr;
  logic [6:0] last_addr;
  logic [15:0] last_data;

  always #2.5 clk = ~clk;

  dac_serial_port dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
    .daisy_en(daisy_en), .sdo(sdo), .sdo_oe(sdo_oe), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
    .rd_data(rd_data), .busy(busy));

  assign rd_data = {req_addr, 9'h135};

  always @(posedge clk) begin
    if (busy) bcyc <= bcyc + 1;
    if (req_valid) begin
      nreq <= nreq + 1;
      last_wr <= req_write;
      last_addr <= req_addr;
      last_data <= req_data;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [47:0] w, input int n);
    nreq = 0; bcyc = 0; cap = '0;
    sync_n = 0;
    wcyc(2 * HP);
    for (int i = n - 1; i >= 0; i--) begin
      din = w[i];
      wcyc(HP);
      cap = {cap[46:0], sdo};
      sclk = 1;
      wcyc(HP);
      sclk = 0;
    end
    wcyc(HP);
    sync_n = 1;
    wcyc(20);
  endtask

  localparam int NV = 6;
  localparam logic [30:0] VEC [NV] = '{
    {6'd24, 24'h12ABCD, 1'b1},
    {6'd24, 24'h7F0001, 1'b1},
    {6'd23, 24'h123456, 1'b0},
    {6'd25, 24'h654321, 1'b0},
    {6'd24, 24'h000000, 1'b0},
    {6'd24, 24'h000001, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wcyc(5);
    chk(req_valid == 0 && busy == 0 && sdo == 0 && sdo_oe == 0, "R1 reset",
        {req_valid, busy, sdo, sdo_oe}, 0);
    rst_n = 1;
    wcyc(5);

    for (int v = 0; v < NV; v++) begin
      logic [23:0] w;
      logic e;
      w = VEC[v][24:1];
      e = VEC[v][0];
      frame({24'h0, w} | (VEC[v][30:25] == 25 ? 48'h1000000 : 48'h0), int'(VEC[v][30:25]));
      chk(nreq == int'(e), "R2/R3/R4 request count", nreq, e);
      if (e) begin
        chk(last_wr == 1 && last_addr == w[22:16] && last_data == w[15:0], "R2 write fields",
            {last_wr, last_addr, last_data}, {1'b1, w[22:0]});
        chk(bcyc == 6, "R9 busy length", bcyc, 6);
      end else chk(bcyc == 0, "R9 no busy when dropped", bcyc, 0);
    end

    frame(48'h950000, 24);
    chk(nreq == 1 && last_wr == 0 && last_addr == 7'h15, "R5 read request",
        {nreq[7:0], last_wr, last_addr}, {8'd1, 1'b0, 7'h15});
    chk(bcyc == 0, "R9 read leaves busy low", bcyc, 0);
    frame(48'h0, 24);
    chk(cap[23:0] == {1'b0, 7'h15, 7'h15, 9'h135}, "R5 readback data", cap[23:0],
        {1'b0, 7'h15, 7'h15, 9'h135});
    chk(nreq == 0, "R4 nop during readback", nreq, 0);
    frame(48'h0, 24);
    chk(cap[23:0] == 0, "R6 sdo quiet without read", cap[23:0], 0);

    sync_n = 0;
    wcyc(6);
    chk(sdo_oe == 1, "R10 oe while framed", sdo_oe, 1);
    sync_n = 1;
    wcyc(6);
    chk(sdo_oe == 0, "R10 oe idle", sdo_oe, 0);

    daisy_en = 1;
    wcyc(4);
    frame(48'h3C5A69_2A1234, 48);
    chk(cap[23:0] == 24'h3C5A69, "R7 pass-through delay", cap[23:0], 24'h3C5A69);
    chk(nreq == 1 && last_wr == 1 && last_addr == 7'h2A && last_data == 16'h1234,
        "R8 last word committed", {last_addr, last_data}, {7'h2A, 16'h1234});
    frame(48'hABCDE, 20);
    chk(nreq == 0, "R8 short chain frame dropped", nreq, 0);
    frame(48'hD50000, 24);
    chk(nreq == 0, "R8 read flag dropped in chain", nreq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule